// File: doc/BRIEF.md
# Link Self-Test Pattern Engine

This block is the loopback self-test section of a serial storage link layer. The transport layer raises a request once a self-test activation frame has been exchanged in either direction. The engine then takes the two 32-bit pattern words offered with that request and arms itself. It waits until the far end sends a SYNC primitive before it switches into its test state.

While in the test state, the engine drives a continuous stream of data words that alternates between the two stored patterns. At the same time it watches the incoming word stream. It first aligns to the far end's sequence and then compares every received word against the word it expects next. An error flag summarises the outcome. The flag is high until a correct sequence has been seen, and it goes high again on any later mismatch.

An exit input, or a synchronous reset, returns the engine to idle and stops the pattern stream.

Top module: `lnk_selftest_engine`

## Requirements
- R1: After a synchronous reset, `bist_active` is 0, `tx_word` is 0, `tx_ctl` is 0 and `bist_err` is 1.
- R2: A request on `bist_req` is taken only from idle, and on that edge it stores `pat_a` and `pat_b`. Changes to the pattern inputs, and requests made while armed or running, have no effect on the transmitted stream.
- R3: Once armed, the engine enters the test state (`bist_active` = 1 after that edge) only on a received word with `rx_ctl` = 1 and `rx_word` equal to the SYNC value (default 32'hB5B5957C). The same value with `rx_ctl` = 0, any other control word, or a SYNC without a prior request leaves `bist_active` at 0.
- R4: In the test state, `tx_word` carries stored pattern A in the first cycle after `bist_active` rises, then B, then A, and so on alternately. `tx_ctl` stays 0 throughout.
- R5: On the edge that enters the test state, `bist_err` is set to 1, whatever its previous value.
- R6: The error flag clears on the edge that samples a data word (`rx_ctl` = 0) equal to B, provided the word sampled just before it was a data word equal to A. Repeated A words keep the search waiting for B.
- R7: After lock, each received word must be the next word of the A/B alternation, as a data word. A word with a different value, or with `rx_ctl` = 1, sets `bist_err` on that edge, and the flag stays set until a new A-then-B pair is seen.
- R8: `bist_exit` returns the engine to idle on the next edge: `bist_active` goes to 0, `tx_word` to 0, and `bist_err` keeps its value. `bist_exit` takes priority over a simultaneous `bist_req`.
- R9: A new request and SYNC after an exit start a fresh test with the newly stored patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bist_req | input | 1 | Self-test request from the transport layer |
| bist_exit | input | 1 | Leave self-test and return to idle |
| pat_a | input | 32 | First pattern word, stored on request |
| pat_b | input | 32 | Second pattern word, stored on request |
| rx_word | input | 32 | Received word |
| rx_ctl | input | 1 | Received word is a primitive (control) |
| tx_word | output | 32 | Transmitted word |
| tx_ctl | output | 1 | Transmitted word is a primitive (always 0 here) |
| bist_active | output | 1 | Engine is in the test state |
| bist_err | output | 1 | Received stream not locked or mismatched |

## Verification
The case hardest to reach is a relock after a post-lock mismatch in which the offending word carries pattern A's value but has the control flag set. Getting there takes a full sequence: request, a filtered wait for SYNC, and an initial lock. Only then can the error be provoked and a fresh A-then-B pair be shown to clear it again. The stimulus walks that path in one scenario. Along the way it also feeds out-of-order and repeated pattern words, so that both branches of the alignment search are taken.

// File: rtl/lnk_bist_pkg.sv
package lnk_bist_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_RUN} lb_state_e;
  typedef enum logic [1:0] {CK_SEEK_A, CK_SEEK_B, CK_LOCKED} lb_chk_e;
endpackage

// File: rtl/lnk_bist_ctrl.sv
module lnk_bist_ctrl
  import lnk_bist_pkg::*;
#(
  parameter int           W         = 32,
  parameter logic [W-1:0] SYNC_WORD = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req,
  input  logic         stop,
  input  logic [W-1:0] rx_word,
  input  logic         rx_ctl,
  output logic         accept,
  output logic         enter_now,
  output logic         run
);
  lb_state_e st_q, st_d;
  logic      sync_hit;

  assign sync_hit = rx_ctl && (rx_word == SYNC_WORD);

  always_comb begin
    st_d      = st_q;
    accept    = 1'b0;
    enter_now = 1'b0;
    if (stop) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE:  if (req) begin st_d = ST_ARMED; accept = 1'b1; end
        ST_ARMED: if (sync_hit) begin st_d = ST_RUN; enter_now = 1'b1; end
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  assign run = (st_q == ST_RUN);

  AST_ENTRY_NEEDS_SYNC: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> $past(rx_ctl && (rx_word == SYNC_WORD))); // R3
  AST_EXIT_IDLES: assert property (@(posedge clk) disable iff (rst)
    stop |=> !run); // R8
endmodule

// File: rtl/lnk_bist_patgen.sv
module lnk_bist_patgen #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         stop,
  input  logic [W-1:0] pa,
  input  logic [W-1:0] pb,
  output logic [W-1:0] tx_word,
  output logic         tx_ctl
);
  logic sel_b;

  always_ff @(posedge clk) begin
    tx_ctl <= 1'b0;
    if (rst || !run || stop) begin
      tx_word <= '0;
      sel_b   <= 1'b0;
    end else begin
      tx_word <= sel_b ? pb : pa;
      sel_b   <= ~sel_b;
    end
  end

  AST_QUIET_OUTSIDE_RUN: assert property (@(posedge clk) disable iff (rst)
    !run |=> (tx_word == '0)); // R8
  AST_TX_IS_PATTERN: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> ((tx_word == pa) || (tx_word == pb))); // R4
endmodule

// File: rtl/lnk_bist_checker.sv
module lnk_bist_checker
  import lnk_bist_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         stop,
  input  logic         enter_now,
  input  logic [W-1:0] pa,
  input  logic [W-1:0] pb,
  input  logic [W-1:0] rx_word,
  input  logic         rx_ctl,
  output logic         err
);
  lb_chk_e ck_q;
  logic    want_b;
  logic    is_a, is_b;

  assign is_a = !rx_ctl && (rx_word == pa);
  assign is_b = !rx_ctl && (rx_word == pb);

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_q <= CK_SEEK_A; want_b <= 1'b0; err <= 1'b1;
    end else if (enter_now) begin
      ck_q <= CK_SEEK_A; want_b <= 1'b0; err <= 1'b1;
    end else if (!run || stop) begin
      ck_q <= CK_SEEK_A; want_b <= 1'b0;
    end else begin
      case (ck_q)
        CK_SEEK_A: if (is_a) ck_q <= CK_SEEK_B;
        CK_SEEK_B: begin
          if (is_b) begin
            ck_q <= CK_LOCKED; want_b <= 1'b0; err <= 1'b0;
          end else if (!is_a) begin
            ck_q <= CK_SEEK_A;
          end
        end
        CK_LOCKED: begin
          if (want_b ? is_b : is_a) begin
            want_b <= ~want_b;
          end else begin
            err    <= 1'b1;
            want_b <= 1'b0;
            ck_q   <= is_a ? CK_SEEK_B : CK_SEEK_A;
          end
        end
        default: ck_q <= CK_SEEK_A;
      endcase
    end
  end

  AST_ERR_SET_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
    enter_now |=> err); // R5
  AST_CLEAR_NEEDS_B: assert property (@(posedge clk) disable iff (rst)
    $fell(err) |-> $past(!rx_ctl && (rx_word == pb))); // R6
endmodule

// File: rtl/lnk_selftest_engine.sv
module lnk_selftest_engine #(
  parameter int           W         = 32,
  parameter logic [W-1:0] SYNC_WORD = 32'hB5B5_957C
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bist_req,
  input  logic         bist_exit,
  input  logic [W-1:0] pat_a,
  input  logic [W-1:0] pat_b,
  input  logic [W-1:0] rx_word,
  input  logic         rx_ctl,
  output logic [W-1:0] tx_word,
  output logic         tx_ctl,
  output logic         bist_active,
  output logic         bist_err
);
  logic         accept, enter_now, run;
  logic [W-1:0] pa_q, pb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pa_q <= '0;
      pb_q <= '0;
    end else if (accept) begin
      pa_q <= pat_a;
      pb_q <= pat_b;
    end
  end

  lnk_bist_ctrl #(.W(W), .SYNC_WORD(SYNC_WORD)) u_ctrl (
    .clk(clk), .rst(rst), .req(bist_req), .stop(bist_exit),
    .rx_word(rx_word), .rx_ctl(rx_ctl),
    .accept(accept), .enter_now(enter_now), .run(run)
  );

  lnk_bist_patgen #(.W(W)) u_gen (
    .clk(clk), .rst(rst), .run(run), .stop(bist_exit),
    .pa(pa_q), .pb(pb_q), .tx_word(tx_word), .tx_ctl(tx_ctl)
  );

  lnk_bist_checker #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .run(run), .stop(bist_exit), .enter_now(enter_now),
    .pa(pa_q), .pb(pb_q), .rx_word(rx_word), .rx_ctl(rx_ctl), .err(bist_err)
  );

  assign bist_active = run;

  AST_PATTERNS_HELD: assert property (@(posedge clk) disable iff (rst)
    run |=> $stable(pa_q) && $stable(pb_q)); // R2
endmodule

// File: tb/lnk_selftest_engine_tb.sv
`timescale 1ns/1ps
module lnk_selftest_engine_tb;
  localparam logic [31:0] SYNC = 32'hB5B5_957C;
  localparam logic [31:0] A1 = 32'h1234_5678, B1 = 32'hCAFE_0F0F;
  localparam logic [31:0] A2 = 32'h0BAD_F00D, B2 = 32'h7E57_1234;
  localparam logic [31:0] JUNK = 32'h4A4A_4A4A;

  logic clk = 1'b0;
  logic rst = 1'b1, bist_req = 1'b0, bist_exit = 1'b0, rx_ctl = 1'b0;
  logic [31:0] pat_a = '0, pat_b = '0, rx_word = '0;
  logic [31:0] tx_word;
  logic tx_ctl, bist_active, bist_err;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  lnk_selftest_engine u_dut (
    .clk(clk), .rst(rst), .bist_req(bist_req), .bist_exit(bist_exit),
    .pat_a(pat_a), .pat_b(pat_b), .rx_word(rx_word), .rx_ctl(rx_ctl),
    .tx_word(tx_word), .tx_ctl(tx_ctl), .bist_active(bist_active), .bist_err(bist_err)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rx(logic [31:0] w, logic c);
    rx_word = w;
    rx_ctl  = c;
    tick();
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0;
    chk("R1 active", 32'(bist_active), 0);
    chk("R1 tx_word", tx_word, 0);
    chk("R1 tx_ctl", 32'(tx_ctl), 0);
    chk("R1 err", 32'(bist_err), 1);
  endtask

  task automatic t_sync_without_request();
    rx(SYNC, 1'b1);
    chk("R3 sync without request", 32'(bist_active), 0);
    rx(JUNK, 1'b0);
  endtask

  task automatic t_arm_and_stream();
    pat_a = A1; pat_b = B1; bist_req = 1'b1; tick(); bist_req = 1'b0;
    pat_a = JUNK; pat_b = JUNK;
    rx(JUNK, 1'b1);
    chk("R3 other primitive", 32'(bist_active), 0);
    rx(SYNC, 1'b0);
    chk("R3 sync value as data", 32'(bist_active), 0);
    rx(SYNC, 1'b1);
    chk("R3 entry on sync", 32'(bist_active), 1);
    chk("R5 err on entry", 32'(bist_err), 1);
    chk("R4 tx idle on entry edge", tx_word, 0);
    rx(JUNK, 1'b0);
    chk("R4 first word A", tx_word, A1);
    chk("R4 tx_ctl low", 32'(tx_ctl), 0);
    rx(JUNK, 1'b0);
    chk("R4 second word B", tx_word, B1);
    rx(JUNK, 1'b0);
    chk("R2 R4 third word A latched", tx_word, A1);
  endtask

  task automatic t_lock_and_errors();
    rx(B1, 1'b0); chk("R6 B before A", 32'(bist_err), 1);
    rx(A1, 1'b0); chk("R6 A alone", 32'(bist_err), 1);
    rx(A1, 1'b0); chk("R6 repeated A", 32'(bist_err), 1);
    rx(B1, 1'b0); chk("R6 lock after A,B", 32'(bist_err), 0);
    rx(A1, 1'b0); chk("R7 locked A", 32'(bist_err), 0);
    rx(B1, 1'b0); chk("R7 locked B", 32'(bist_err), 0);
    rx(A1, 1'b0); chk("R7 locked A again", 32'(bist_err), 0);
    rx(JUNK, 1'b0); chk("R7 value mismatch", 32'(bist_err), 1);
    rx(B1, 1'b0); chk("R7 sticky after mismatch", 32'(bist_err), 1);
    rx(A1, 1'b0); chk("R7 sticky on A", 32'(bist_err), 1);
    rx(B1, 1'b0); chk("R7 relock", 32'(bist_err), 0);
    rx(A1, 1'b1); chk("R7 control flag mismatch", 32'(bist_err), 1);
    rx(A1, 1'b0); chk("R7 sticky after ctl mismatch", 32'(bist_err), 1);
    rx(B1, 1'b0); chk("R7 relock after ctl mismatch", 32'(bist_err), 0);
  endtask

  task automatic t_exit();
    bist_exit = 1'b1; bist_req = 1'b1; pat_a = A2; pat_b = B2;
    rx(A1, 1'b0);
    bist_exit = 1'b0; bist_req = 1'b0;
    chk("R8 inactive after exit", 32'(bist_active), 0);
    chk("R8 tx quiet after exit", tx_word, 0);
    chk("R8 err held", 32'(bist_err), 0);
    rx(SYNC, 1'b1);
    chk("R8 exit beats request", 32'(bist_active), 0);
  endtask

  task automatic t_reentry();
    pat_a = A2; pat_b = B2; bist_req = 1'b1; rx(JUNK, 1'b0); bist_req = 1'b0;
    rx(SYNC, 1'b1);
    chk("R9 re-entry active", 32'(bist_active), 1);
    chk("R9 R5 err set again", 32'(bist_err), 1);
    bist_req = 1'b1; pat_a = JUNK; pat_b = JUNK;
    rx(JUNK, 1'b0);
    bist_req = 1'b0;
    chk("R9 new pattern A", tx_word, A2);
    rx(JUNK, 1'b0);
    chk("R2 request while running ignored", tx_word, B2);
    rx(JUNK, 1'b0);
    chk("R2 stream continues", tx_word, A2);
  endtask

  task automatic t_reset_midrun();
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R1 reset mid-run active", 32'(bist_active), 0);
    chk("R1 reset mid-run tx", tx_word, 0);
    chk("R1 reset mid-run err", 32'(bist_err), 1);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_sync_without_request();
    t_arm_and_stream();
    t_lock_and_errors();
    t_exit();
    t_reentry();
    t_reset_midrun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule